// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block turns one pulse-width command and one low-side mode input into two gate enables for a complementary half bridge: one for the upper switch and one for the lower switch. The command is inverted: a high command turns the upper switch off and lets the lower switch conduct. A low command turns the upper switch on. Between any switch turning off and the other turning on, the block holds both enables low for a dead time. The dead time has one length for the falling switch-node transition and another for the rising one.

The mode input is judged by its activity as well as its level. A steady high level gives synchronous operation. A steady low level keeps the lower switch off, so only the upper switch follows the command. A mode input that toggles faster than a set edge spacing is taken as a request for synchronous switching, and that request is held until the input has been quiet for a filter time. Both inputs are synchronised, and the command must hold a new level for a minimum number of cycles before it is accepted. A protection force-off input overrides everything else. When force-off is released, the dead-time count starts again from zero.

Top module: `hb_gate_seq`

## Requirements
- R1: Once settled, an accepted high command gives upper gate 0 and lower gate 1 in a synchronous mode. An accepted low command gives upper gate 1 and lower gate 0 in every mode.
- R2: With the mode input held low and not toggling, the mode output is 2'b00 and the lower gate stays 0 whatever the command is. With a high command, both gates are 0.
- R3: With the mode input held high and not toggling, the mode output is 2'b01 and both gates follow the command as in R1.
- R4: When two successive mode-input edges are at most DET_GAP cycles apart, the block enters toggle-synchronous mode. The mode output is 2'b10 and both gates follow the command. The mode output never takes the value 2'b11.
- R5: Toggle-synchronous mode is kept until FILT_CYC cycles pass with no mode-input edge. After that, the static level chooses between 2'b01 and 2'b00.
- R6: Edges spaced more than DET_GAP cycles apart never start toggle-synchronous mode. The mode then tracks the level.
- R7: When the upper gate falls, the lower gate rises after exactly DT_HL cycles with both gates low. When the lower gate falls, the upper gate rises after exactly DT_LH cycles with both gates low.
- R8: The two gates are never high in the same cycle.
- R9: A command level held for fewer than MIN_PULSE synchronised samples has no effect on the gates. A level held for exactly MIN_PULSE samples is accepted.
- R10: During reset and after it, the command counts as high and the mode input as low. Both gates are 0 and the mode is 2'b00 while reset is held. The upper gate stays 0 for at least MIN_PULSE cycles after release, even with a low command.
- R11: In the cycle after force_off is sampled high, both gates are 0, and they stay 0 while force_off stays high.
- R12: After force_off falls, both gates stay low for the full dead time of the gate about to turn on, counted from the first cycle without force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one cycle per timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous switching command, high turns the upper switch off |
| lscon_in | input | 1 | Asynchronous low-side mode input, judged by level and by toggle rate |
| force_off | input | 1 | Protection override, drives both gates low |
| hs_gate | output | 1 | Upper switch enable |
| ls_gate | output | 1 | Lower switch enable |
| mode_o | output | 2 | Current mode: 00 upper only, 01 static synchronous, 10 toggle synchronous |

## Verification
The checker watches, on every cycle, that the gates never overlap and that each rising gate is preceded by its own dead time. It also checks that the dead time counts again after a force-off is released, that force-off clears both gates one cycle later, that an accepted command level keeps the forbidden gate low, and that upper-only mode never lets the lower gate conduct. The bench scenarios show the behaviours that depend on history spanning many cycles. These are the exact dead-time lengths, the minimum-pulse boundary at one sample either side, entry into toggle mode from fast edges, its hold through the filter time, its exit to the correct static mode, and the rejection of slow edges. Random static-mode sequences with occasional force pulses are compared against the bench's own gate table.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [1:0] {
    MODE_HS_ONLY     = 2'b00,
    MODE_SYNC_STATIC = 2'b01,
    MODE_SYNC_TOGGLE = 2'b10
  } ls_mode_e;

  // Mode choice: toggle activity wins over the static level.
  function automatic ls_mode_e pick_mode(input logic toggling, input logic level);
    if (toggling) return MODE_SYNC_TOGGLE;
    if (level)    return MODE_SYNC_STATIC;
    return MODE_HS_ONLY;
  endfunction

  // Requested gates {upper, lower} for an accepted command level.
  function automatic logic [1:0] gate_request(input logic cmd_high, input ls_mode_e mode);
    if (!cmd_high)             return 2'b10;
    if (mode == MODE_HS_ONLY)  return 2'b00;
    return 2'b01;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= {2{RST_VAL}};
    else        stage <= {stage[0], d_async};
  end

  assign q_sync = stage[1];
endmodule

// File: rtl/hbg_pulse_qual.sv
module hbg_pulse_qual #(
  parameter int   MIN_PULSE = 13,
  parameter logic RST_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic lvl_q
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_PULSE - 1);

  logic [CW-1:0] run_cnt;

  // A new level is taken only after MIN_PULSE consecutive differing samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= RST_VAL;
      run_cnt <= '0;
    end else if (lvl_in == lvl_q) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      lvl_q   <= lvl_in;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hbg_toggle_det.sv
module hbg_toggle_det #(
  parameter int DET_GAP  = 139,
  parameter int FILT_CYC = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic toggling
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] GAP_LIM   = CW'(DET_GAP);
  localparam logic [CW-1:0] FILT_LAST = CW'(FILT_CYC - 1);
  localparam logic [CW-1:0] SAT       = CW'(FILT_CYC);

  logic          prev_lvl;
  logic [CW-1:0] since_edge;
  logic          edge_seen;

  assign edge_seen = lvl_in ^ prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl   <= 1'b0;
      since_edge <= SAT;
      toggling   <= 1'b0;
    end else begin
      prev_lvl <= lvl_in;
      if (edge_seen) begin
        if (since_edge < GAP_LIM) toggling <= 1'b1;
        since_edge <= '0;
      end else begin
        if (since_edge != SAT)       since_edge <= since_edge + 1'b1;
        if (since_edge == FILT_LAST) toggling   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hbg_dead_time.sv
module hbg_dead_time #(
  parameter int DT_HL = 3,
  parameter int DT_LH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_off,
  input  logic want_hs,
  input  logic want_ls,
  output logic hs_on,
  output logic ls_on,
  output logic hs_ready,
  output logic ls_ready
);
  localparam int DT_MAX = (DT_HL > DT_LH) ? DT_HL : DT_LH;
  localparam int CW     = $clog2(DT_MAX + 1);
  localparam logic [CW-1:0] HS_WAIT  = CW'(DT_LH - 1);
  localparam logic [CW-1:0] LS_WAIT  = CW'(DT_HL - 1);
  localparam logic [CW-1:0] IDLE_SAT = CW'(DT_MAX - 1);

  logic [CW-1:0] idle_cnt;

  assign hs_ready = (idle_cnt >= HS_WAIT);
  assign ls_ready = (idle_cnt >= LS_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      idle_cnt <= '0;
    end else if (force_off) begin
      hs_on    <= 1'b0;
      ls_on    <= 1'b0;
      idle_cnt <= '0;
    end else if (hs_on) begin
      if (!want_hs) begin
        hs_on    <= 1'b0;
        idle_cnt <= '0;
      end
    end else if (ls_on) begin
      if (!want_ls) begin
        ls_on    <= 1'b0;
        idle_cnt <= '0;
      end
    end else if (want_hs && hs_ready) begin
      hs_on <= 1'b1;
    end else if (want_ls && ls_ready) begin
      ls_on <= 1'b1;
    end else if (idle_cnt != IDLE_SAT) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hbg_pkg::*;
#(
  parameter int DT_HL     = 3,
  parameter int DT_LH     = 4,
  parameter int MIN_PULSE = 13,
  parameter int DET_GAP   = 139,
  parameter int FILT_CYC  = 600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       lscon_in,
  input  logic       force_off,
  output logic       hs_gate,
  output logic       ls_gate,
  output logic [1:0] mode_o
);
  logic       pwm_s;
  logic       lscon_s;
  logic       pwm_q;
  logic       toggling;
  ls_mode_e   mode;
  logic [1:0] req;
  logic       hs_ready;
  logic       ls_ready;

  hbg_sync #(.RST_VAL(1'b1)) u_sync_pwm (
    .clk(clk), .rst_n(rst_n), .d_async(pwm_in), .q_sync(pwm_s)
  );

  hbg_sync #(.RST_VAL(1'b0)) u_sync_lscon (
    .clk(clk), .rst_n(rst_n), .d_async(lscon_in), .q_sync(lscon_s)
  );

  hbg_pulse_qual #(.MIN_PULSE(MIN_PULSE), .RST_VAL(1'b1)) u_qual (
    .clk(clk), .rst_n(rst_n), .lvl_in(pwm_s), .lvl_q(pwm_q)
  );

  hbg_toggle_det #(.DET_GAP(DET_GAP), .FILT_CYC(FILT_CYC)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl_in(lscon_s), .toggling(toggling)
  );

  assign mode = pick_mode(toggling, lscon_s);
  assign req  = gate_request(pwm_q, mode);

  hbg_dead_time #(.DT_HL(DT_HL), .DT_LH(DT_LH)) u_dt (
    .clk(clk), .rst_n(rst_n), .force_off(force_off),
    .want_hs(req[1]), .want_ls(req[0]),
    .hs_on(hs_gate), .ls_on(ls_gate),
    .hs_ready(hs_ready), .ls_ready(ls_ready)
  );

  assign mode_o = mode;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
  parameter int DT_HL = 3,
  parameter int DT_LH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       force_off,
  input logic       pwm_q,
  input logic [1:0] mode_o,
  input logic       hs_gate,
  input logic       ls_gate
);
  logic [15:0] off_run;
  logic [15:0] since_force;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run     <= '0;
      since_force <= '0;
    end else begin
      if (hs_gate || ls_gate)     off_run <= '0;
      else if (off_run != 16'hFFFF) off_run <= off_run + 1'b1;
      if (force_off)                  since_force <= '0;
      else if (since_force != 16'hFFFF) since_force <= since_force + 1'b1;
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) !(hs_gate && ls_gate)); // R8
  AST_HL_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_gate) |-> off_run >= 16'(DT_HL)); // R7
  AST_LH_GAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_gate) |-> off_run >= 16'(DT_LH)); // R7
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) force_off |=> (!hs_gate && !ls_gate)); // R11
  AST_RELEASE_HS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs_gate) |-> since_force >= 16'(DT_LH)); // R12
  AST_RELEASE_LS_WAIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls_gate) |-> since_force >= 16'(DT_HL)); // R12
  AST_HS_ONLY_NO_LS: assert property (@(posedge clk) disable iff (!rst_n) (mode_o == 2'b00 && $past(mode_o) == 2'b00) |-> !ls_gate); // R2
  AST_CMD_HIGH_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (pwm_q && $past(pwm_q)) |-> !hs_gate); // R1
  AST_CMD_LOW_LS_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!pwm_q && !$past(pwm_q)) |-> !ls_gate); // R1
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mode_o)); // R4
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DT_HL(DT_HL), .DT_LH(DT_LH)) u_chk (
  .clk(clk), .rst_n(rst_n), .force_off(force_off), .pwm_q(pwm_q),
  .mode_o(mode_o), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  localparam int DT_HL = 3;
  localparam int DT_LH = 4;
  localparam int MIN_PULSE = 13;
  localparam int DET_GAP = 139;
  localparam int FILT_CYC = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0;
  logic lscon_in = 1'b0;
  logic force_off = 1'b0;
  logic hs_gate, ls_gate;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hb_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .lscon_in(lscon_in),
    .force_off(force_off), .hs_gate(hs_gate), .ls_gate(ls_gate), .mode_o(mode_o)
  );

  // Bench's own view of the gate table: {upper, lower}
  function automatic logic [1:0] exp_gates(input logic cmd, input logic [1:0] md);
    logic [1:0] g;
    g = 2'b00;
    if (cmd == 1'b0) g = 2'b10;
    else if (md != 2'b00) g = 2'b01;
    return g;
  endfunction

  function automatic logic [1:0] exp_static_mode(input logic lvl);
    return lvl ? 2'b01 : 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Count both-low samples between one gate falling and the other rising.
  task automatic measure_gap(output int gap);
    logic old_hs;
    old_hs = hs_gate;
    gap = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!hs_gate && !ls_gate) gap++;
      else if (hs_gate != old_hs) break;
    end
  endtask

  task automatic toggle_lscon(input int edges, input int half);
    for (int i = 0; i < edges; i++) begin
      lscon_in = ~lscon_in;
      wait_cyc(half);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int gap;
    bit seen;
    void'($urandom(32'd20240611));

    // R10: reset state with command driven low
    wait_cyc(5);
    chk("R10 reset gates", {30'd0, hs_gate, ls_gate}, 32'd0);
    chk("R10 reset mode", {30'd0, mode_o}, 32'd0);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < MIN_PULSE; i++) begin
      @(negedge clk);
      if (hs_gate) seen = 1;
    end
    chk("R10 upper held off after release", {31'd0, seen}, 32'd0);
    pwm_in = 1'b1;
    wait_cyc(40);

    // R3 / R1: static high, synchronous
    lscon_in = 1'b1;
    pwm_in = 1'b0;
    wait_cyc(40);
    chk("R3 static mode", {30'd0, mode_o}, 32'd1);
    chk("R1 low command gates", {30'd0, hs_gate, ls_gate}, {30'd0, exp_gates(1'b0, 2'b01)});
    pwm_in = 1'b1;
    measure_gap(gap);
    chk("R7 falling dead time", gap, DT_HL);
    chk("R1 high command gates", {30'd0, hs_gate, ls_gate}, {30'd0, exp_gates(1'b1, 2'b01)});
    pwm_in = 1'b0;
    measure_gap(gap);
    chk("R7 rising dead time", gap, DT_LH);
    wait_cyc(10);

    // R9: minimum pulse boundary
    pwm_in = 1'b1;
    wait_cyc(MIN_PULSE - 1);
    pwm_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!hs_gate) seen = 1;
    end
    chk("R9 short pulse ignored", {31'd0, seen}, 32'd0);
    pwm_in = 1'b1;
    wait_cyc(MIN_PULSE);
    pwm_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!hs_gate) seen = 1;
    end
    chk("R9 exact pulse accepted", {31'd0, seen}, 32'd1);
    wait_cyc(40);

    // R2: static low, upper only
    lscon_in = 1'b0;
    wait_cyc(10);
    chk("R2 mode", {30'd0, mode_o}, 32'd0);
    pwm_in = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ls_gate) seen = 1;
    end
    chk("R2 high command both off", {30'd0, hs_gate, ls_gate}, 32'd0);
    pwm_in = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ls_gate) seen = 1;
    end
    chk("R2 upper follows", {30'd0, hs_gate, ls_gate}, 32'd2);
    chk("R2 lower never on", {31'd0, seen}, 32'd0);

    // R4: toggle-synchronous mode
    pwm_in = 1'b1;
    toggle_lscon(10, 40);
    chk("R4 toggle mode", {30'd0, mode_o}, 32'd2);
    chk("R4 high command gates", {30'd0, hs_gate, ls_gate}, 32'd1);
    pwm_in = 1'b0;
    toggle_lscon(6, 40);
    chk("R4 low command gates", {30'd0, hs_gate, ls_gate}, 32'd2);
    pwm_in = 1'b1;
    toggle_lscon(6, 40);
    chk("R4 lower back on", {30'd0, hs_gate, ls_gate}, 32'd1);

    // R5: hold through filter, then static low -> float
    wait_cyc(FILT_CYC / 2);
    chk("R5 mode held", {30'd0, mode_o}, 32'd2);
    chk("R5 lower held on", {30'd0, hs_gate, ls_gate}, 32'd1);
    wait_cyc(FILT_CYC / 2 + 100);
    chk("R5 exit to static low", {30'd0, mode_o}, 32'd0);
    chk("R5 both gates off", {30'd0, hs_gate, ls_gate}, 32'd0);
    toggle_lscon(11, 40);
    wait_cyc(FILT_CYC + 100);
    chk("R5 exit to static high", {30'd0, mode_o}, 32'd1);
    chk("R5 lower on after exit high", {30'd0, hs_gate, ls_gate}, 32'd1);

    // R6: slow edges never count as toggling
    for (int i = 0; i < 4; i++) begin
      lscon_in = ~lscon_in;
      wait_cyc(2 * DET_GAP + 20);
      chk("R6 slow edges track level", {30'd0, mode_o}, {30'd0, exp_static_mode(lscon_in)});
    end

    // R11 / R12: force-off and restart of the dead time
    lscon_in = 1'b1;
    pwm_in = 1'b0;
    wait_cyc(60);
    force_off = 1'b1;
    @(negedge clk);
    chk("R11 force clears upper", {30'd0, hs_gate, ls_gate}, 32'd0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hs_gate || ls_gate) seen = 1;
    end
    chk("R11 held off", {31'd0, seen}, 32'd0);
    force_off = 1'b0;
    gap = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!hs_gate && !ls_gate) gap++;
      else break;
    end
    chk("R12 upper waits after release", gap, DT_LH);
    pwm_in = 1'b1;
    wait_cyc(40);
    force_off = 1'b1;
    wait_cyc(5);
    force_off = 1'b0;
    gap = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!hs_gate && !ls_gate) gap++;
      else break;
    end
    chk("R12 lower waits after release", gap, DT_HL);
    chk("R12 lower resumes", {30'd0, hs_gate, ls_gate}, 32'd1);

    // Random static-mode sequences with occasional force pulses
    for (int it = 0; it < 40; it++) begin
      logic lv, cmd;
      lv = 1'($urandom % 2);
      cmd = 1'($urandom % 2);
      lscon_in = lv;
      pwm_in = cmd;
      if (($urandom % 4) == 0) begin
        force_off = 1'b1;
        wait_cyc(1 + ($urandom % 6));
        force_off = 1'b0;
      end
      wait_cyc(2 * DET_GAP + ($urandom % 60));
      chk("R1 R2 R3 random gates", {30'd0, hs_gate, ls_gate},
          {30'd0, exp_gates(cmd, exp_static_mode(lv))});
      chk("R6 random mode", {30'd0, mode_o}, {30'd0, exp_static_mode(lv)});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule